// File: doc/BRIEF.md
# Byte-Register Execute Unit with Skip

This unit carries out two byte-oriented operations of an 8-bit accumulator machine against a banked file memory that sits outside the block. The first operation inverts a file register. Its result goes either to the working register W or back to the file register. The second operation compares a file register with W. When the two are equal, it discards the instruction that has already been fetched.

Every instruction cycle is four clocks long and always runs in the same order: decode, read, process, write. The fetch side presents a 16-bit word during the decode clock. The unit forms a 12-bit data address from three things: the 8-bit file field, a per-instruction bank-mode bit, and a bank register input. When the indexed mode input is on, low access addresses are offset from a pointer input.

A taken skip raises `skip_flush` for one whole instruction cycle. If the fetch side reports that the discarded instruction is two words long, the flag stays up for two cycles. While the flag is up, the unit treats whatever it is handed as a no-op.

Top module: `byx_exec`

## Requirements
- R1: After synchronous reset, W, N and Z read 0, `skip_flush` and `mem_we` are low, and `phase_q1` is high in the first clock after reset.
- R2: Word `0001_11da ffff_ffff` with d=1 drives `mem_we` high during the write clock, with `mem_wdata` equal to the bitwise inverse of the byte read at `mem_addr`. W is left unchanged.
- R3: The same word with d=0 loads the inverted byte into W at the end of the instruction cycle and performs no memory write.
- R4: After the inversion, N equals bit 7 of the result and Z is 1 exactly when the result is 0x00.
- R5: Word `0110_001a ffff_ffff` changes neither W, N nor Z, and never writes memory.
- R6: When the compared byte equals W, `skip_flush` is high for the whole next instruction cycle, and the word offered in that cycle has no effect.
- R7: When `next_two_word` is high during that comparison, `skip_flush` stays high for two instruction cycles, and both offered words have no effect.
- R8: When the compared byte differs from W, `skip_flush` stays low.
- R9: With a=1 (bit 8), the address is {bank_sel, f}.
- R10: With a=0 and `ext_en` low, f ≤ 0x5F addresses {0x0, f} and f ≥ 0x60 addresses {0xF, f}.
- R11: With a=0 and `ext_en` high, f ≤ 0x5F addresses `idx_base` + f modulo 4096, and f ≥ 0x60 still addresses {0xF, f}.
- R12: Any other opcode, or a decode clock with `instr_valid` low, causes no write and no change to W, N or Z.
- R13: A cycle starts with `phase_q1` high. `mem_addr` holds the operand address through the read, process and write clocks, and `mem_we` is high only in the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word, sampled at the end of the decode clock |
| instr_valid | input | 1 | The word is a real instruction |
| next_two_word | input | 1 | The already-fetched next instruction is two words long |
| bank_sel | input | 4 | Bank register for bank-mode addressing |
| ext_en | input | 1 | Enables indexed addressing for low access addresses |
| idx_base | input | 12 | Pointer for indexed addressing |
| phase_q1 | output | 1 | High in the decode clock of each instruction cycle |
| mem_addr | output | 12 | File memory address |
| mem_rdata | input | 8 | Asynchronous read data from file memory |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable, sampled by memory at the clock edge |
| w_reg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| skip_flush | output | 1 | Current instruction cycle is a discarded no-op |

## Verification
The bench builds the unit with its default parameters: an 8-bit file field, a 4-bit bank register and the access split at 0x5F. With these values the full 4096-byte space can be modelled, so the bench drives every address path. It covers a bank other than zero, both sides of the access split at f=0x5F and f=0x60, the top special-function page, and an indexed pointer offset. Skips are driven both with single and with double flush lengths. During each flush a live inversion is offered, which must leave memory, W and the flags untouched.

// File: rtl/byx_pkg.sv
package byx_pkg;
    localparam int FILE_W  = 8;
    localparam int BANK_W  = 4;
    localparam int ADDR_W  = FILE_W + BANK_W;
    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int FLUSH_W = 2;

    localparam logic [5:0] OPC_INV = 6'b000111;
    localparam logic [6:0] OPC_CEQ = 7'b0110001;

    typedef enum logic [1:0] {
        PH_DEC  = 2'd0,
        PH_RD   = 2'd1,
        PH_PROC = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INV  = 2'd1,
        OP_CEQ  = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              to_file;
        logic [ADDR_W-1:0] addr;
    } uop_t;

    function automatic logic [ADDR_W-1:0] form_addr(
        input logic              bank_mode,
        input logic [FILE_W-1:0] f,
        input logic [BANK_W-1:0] bank,
        input logic              ext,
        input logic [ADDR_W-1:0] base,
        input logic [FILE_W-1:0] split
    );
        logic [ADDR_W-1:0] r;
        if (bank_mode)
            r = {bank, f};
        else if (f <= split)
            r = ext ? base + ADDR_W'(f) : {{BANK_W{1'b0}}, f};
        else
            r = {{BANK_W{1'b1}}, f};
        return r;
    endfunction
endpackage

// File: rtl/byx_decode.sv
module byx_decode
    import byx_pkg::*;
#(
    parameter logic [FILE_W-1:0] ACCESS_SPLIT = 8'h5F
) (
    input  logic [INSTR_W-1:0] word,
    input  logic               valid,
    input  logic               suppress,
    input  logic [BANK_W-1:0]  bank,
    input  logic               ext,
    input  logic [ADDR_W-1:0]  base,
    output uop_t               uop
);
    logic [FILE_W-1:0] f;
    logic              bank_mode;

    assign f         = word[FILE_W-1:0];
    assign bank_mode = word[8];

    always_comb begin
        uop.op      = OP_NONE;
        uop.to_file = 1'b0;
        uop.addr    = form_addr(bank_mode, f, bank, ext, base, ACCESS_SPLIT);
        if (valid && !suppress) begin
            if (word[15:10] == OPC_INV) begin
                uop.op      = OP_INV;
                uop.to_file = word[9];
            end else if (word[15:9] == OPC_CEQ) begin
                uop.op = OP_CEQ;
            end
        end
    end

    always_comb begin
        assert_inv_needs_valid_R12: assert (!(uop.op != OP_NONE && !valid));
    end
endmodule

// File: rtl/byx_alu.sv
module byx_alu
    import byx_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] w,
    output logic [DATA_W-1:0] result,
    output logic              equal
);
    logic [DATA_W:0] diff;

    always_comb begin
        diff   = {1'b0, operand} - {1'b0, w};
        equal  = (op == OP_CEQ) && (diff == '0);
        result = ~operand;
    end
endmodule

// File: rtl/byx_seq.sv
module byx_seq
    import byx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  logic   two_word,
    output phase_e phase,
    output logic   flushing
);
    logic [FLUSH_W-1:0] flush_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_DEC;
            flush_cnt <= '0;
        end else begin
            phase <= phase_e'(phase + 2'd1);
            if (phase == PH_WR) begin
                if (flush_cnt != '0)
                    flush_cnt <= flush_cnt - 1'b1;
                else if (hit)
                    flush_cnt <= two_word ? FLUSH_W'(2) : FLUSH_W'(1);
            end
        end
    end

    assign flushing = (flush_cnt != '0);

    assert_flush_starts_q1_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flushing) |-> phase == PH_DEC);
    assert_flush_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_DEC) |-> $stable(flushing));
endmodule

// File: rtl/byx_exec.sv
module byx_exec
    import byx_pkg::*;
#(
    parameter logic [FILE_W-1:0] ACCESS_SPLIT = 8'h5F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               instr_valid,
    input  logic               next_two_word,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic               ext_en,
    input  logic [ADDR_W-1:0]  idx_base,
    output logic               phase_q1,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    output logic [DATA_W-1:0]  w_reg,
    output logic               flag_n,
    output logic               flag_z,
    output logic               skip_flush
);
    phase_e            phase;
    uop_t              uop_d, uop_q;
    logic [DATA_W-1:0] operand_q, result_d, result_q;
    logic              eq_d, eq_q, hit;

    byx_decode #(.ACCESS_SPLIT(ACCESS_SPLIT)) u_dec (
        .word     (instr_word),
        .valid    (instr_valid),
        .suppress (skip_flush),
        .bank     (bank_sel),
        .ext      (ext_en),
        .base     (idx_base),
        .uop      (uop_d)
    );

    byx_alu u_alu (
        .op      (uop_q.op),
        .operand (operand_q),
        .w       (w_reg),
        .result  (result_d),
        .equal   (eq_d)
    );

    assign hit = (phase == PH_WR) && (uop_q.op == OP_CEQ) && eq_q;

    byx_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .two_word (next_two_word),
        .phase    (phase),
        .flushing (skip_flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uop_q     <= '0;
            operand_q <= '0;
            result_q  <= '0;
            eq_q      <= 1'b0;
            w_reg     <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
        end else begin
            case (phase)
                PH_DEC:  uop_q     <= uop_d;
                PH_RD:   operand_q <= mem_rdata;
                PH_PROC: begin
                    result_q <= result_d;
                    eq_q     <= eq_d;
                end
                PH_WR: begin
                    if (uop_q.op == OP_INV) begin
                        if (!uop_q.to_file)
                            w_reg <= result_q;
                        flag_n <= result_q[DATA_W-1];
                        flag_z <= (result_q == '0);
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase_q1  = (phase == PH_DEC);
    assign mem_addr  = uop_q.addr;
    assign mem_wdata = result_q;
    assign mem_we    = (phase == PH_WR) && (uop_q.op == OP_INV) && uop_q.to_file;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_q1 && !skip_flush && w_reg == '0));
    assert_we_only_q4_R13: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> phase_q1);
    assert_no_write_in_flush_R6: assert property (@(posedge clk) disable iff (rst)
        skip_flush |-> !mem_we);
    assert_inv_to_w_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR && uop_q.op == OP_INV && !uop_q.to_file) |=> w_reg == $past(result_q));
    assert_flags_from_result_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR && uop_q.op == OP_INV) |=> (flag_n == $past(result_q[DATA_W-1])));
    assert_compare_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR && uop_q.op == OP_CEQ) |=> ($stable(w_reg) && $stable(flag_n) && $stable(flag_z)));
    assert_addr_held_R13: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROC || phase == PH_WR) |-> $stable(mem_addr));
endmodule

// File: tb/sim_byx_exec.sv
`timescale 1ns/1ps
module sim_byx_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_word = '0;
    logic        instr_valid = 1'b0;
    logic        next_two_word = 1'b0;
    logic [3:0]  bank_sel = '0;
    logic        ext_en = 1'b0;
    logic [11:0] idx_base = '0;
    logic        phase_q1;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we;
    logic [7:0]  w_reg;
    logic        flag_n, flag_z, skip_flush;

    logic [7:0] fmem [0:4095];
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    int m_w = 0;
    bit m_n = 0, m_z = 0;
    int m_flush = 0;

    always #4 clk = ~clk;

    byx_exec u0 (
        .clk(clk), .rst(rst), .instr_word(instr_word), .instr_valid(instr_valid),
        .next_two_word(next_two_word), .bank_sel(bank_sel), .ext_en(ext_en),
        .idx_base(idx_base), .phase_q1(phase_q1), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .w_reg(w_reg), .flag_n(flag_n), .flag_z(flag_z), .skip_flush(skip_flush)
    );

    assign mem_rdata = fmem[mem_addr];
    always @(posedge clk) if (mem_we) fmem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic do_op(input logic [15:0] word, input logic vld, input logic tw,
                         input logic [3:0] bk, input logic ex, input logic [11:0] ib,
                         input string rq);
        bit flushed;
        int kind, addr, f, operand, res;
        bit exp_we;
        flushed = (m_flush > 0);
        chk(phase_q1 == 1'b1, "R13", phase_q1, 1);
        chk(skip_flush == flushed, flushed ? "R6" : "R8", skip_flush, flushed);
        instr_word = word; instr_valid = vld; next_two_word = tw;
        bank_sel = bk; ext_en = ex; idx_base = ib;
        kind = 0;
        if (vld && !flushed) begin
            if (word[15:10] == 6'b000111) kind = 1;
            else if (word[15:9] == 7'b0110001) kind = 2;
        end
        f = word[7:0];
        if (word[8]) addr = bk * 256 + f;
        else if (f <= 95) addr = ex ? (ib + f) % 4096 : f;
        else addr = 15 * 256 + f;
        operand = fmem[addr];
        res = (~operand) & 255;
        for (int p = 1; p <= 3; p++) begin
            @(posedge clk); @(negedge clk);
            if (kind != 0) chk(mem_addr == addr, rq, mem_addr, addr);
            exp_we = (p == 3) && (kind == 1) && word[9];
            chk(mem_we == exp_we, (kind == 1) ? rq : "R13", mem_we, exp_we);
            if (exp_we) chk(mem_wdata == res, "R2", mem_wdata, res);
        end
        @(posedge clk); @(negedge clk);
        if (kind == 1) begin
            if (!word[9]) m_w = res;
            m_n = res[7];
            m_z = (res == 0);
        end
        if (m_flush > 0) m_flush--;
        else if (kind == 2 && operand == m_w) m_flush = tw ? 2 : 1;
        chk(w_reg == m_w, rq, w_reg, m_w);
        chk(flag_n == m_n, rq, flag_n, m_n);
        chk(flag_z == m_z, rq, flag_z, m_z);
        instr_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) fmem[i] = 8'((i * 37 + 5) & 255);
        fmem[12'h320] = 8'h5A;
        fmem[12'h321] = 8'hFF;
        fmem[12'h322] = 8'h01;
        fmem[12'h323] = 8'h77;
        fmem[12'h324] = 8'hFE;
        fmem[12'h327] = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(w_reg == 8'h00, "R1", w_reg, 0);
        chk(flag_n == 1'b0 && flag_z == 1'b0, "R1", {flag_n, flag_z}, 0);
        chk(skip_flush == 1'b0, "R1", skip_flush, 0);
        chk(mem_we == 1'b0, "R1", mem_we, 0);
        chk(phase_q1 == 1'b1, "R1", phase_q1, 1);

        do_op(16'h1F20, 1, 0, 4'h3, 0, 12'h000, "R2");   // invert to file, bank 3
        chk(fmem[12'h320] == 8'hA5, "R2", fmem[12'h320], 8'hA5);
        do_op(16'h1D20, 1, 0, 4'h3, 0, 12'h000, "R3");   // invert to W
        chk(fmem[12'h320] == 8'hA5, "R3", fmem[12'h320], 8'hA5);
        do_op(16'h1D21, 1, 0, 4'h3, 0, 12'h000, "R4");   // zero result
        do_op(16'h1D22, 1, 0, 4'h3, 0, 12'h000, "R4");   // negative result, W=FE
        do_op(16'h6323, 1, 0, 4'h3, 0, 12'h000, "R8");   // not equal
        do_op(16'h6324, 1, 0, 4'h3, 0, 12'h000, "R5");   // equal, single skip
        do_op(16'h1D25, 1, 0, 4'h3, 0, 12'h000, "R6");   // discarded
        do_op(16'h6324, 1, 1, 4'h3, 0, 12'h000, "R7");   // equal, double skip
        do_op(16'h1F26, 1, 0, 4'h3, 0, 12'h000, "R7");   // discarded
        do_op(16'h1D26, 1, 0, 4'h3, 0, 12'h000, "R7");   // discarded
        do_op(16'h1D27, 1, 0, 4'h3, 0, 12'h000, "R3");   // runs again, W=5A
        do_op(16'h1F44, 1, 0, 4'hA, 0, 12'h000, "R9");
        do_op(16'h1E10, 1, 0, 4'h7, 0, 12'h000, "R10");
        do_op(16'h1E5F, 1, 0, 4'h7, 0, 12'h000, "R10");
        do_op(16'h1C60, 1, 0, 4'h7, 0, 12'h000, "R10");
        do_op(16'h1E80, 1, 0, 4'h7, 0, 12'h000, "R10");
        do_op(16'h1E30, 1, 0, 4'h7, 1, 12'h200, "R11");
        do_op(16'h1C5F, 1, 0, 4'h7, 1, 12'hFC0, "R11");
        do_op(16'h1E70, 1, 0, 4'h7, 1, 12'h200, "R11");
        do_op(16'h6230, 1, 0, 4'h7, 1, 12'h200, "R11");
        do_op(16'hFFFF, 1, 0, 4'h3, 0, 12'h000, "R12");
        do_op(16'h1F20, 0, 0, 4'h3, 0, 12'h000, "R12");
        chk(fmem[12'h320] == 8'hA5, "R12", fmem[12'h320], 8'hA5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule